// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one or two DDR2 devices from power-on to an operational state. Out of reset it keeps every clock-enable low and counts the power-up settling interval. It then waits for the PHY delay line to report lock. After that it walks each device through the mode-register programming order that DDR2 requires. All intervals are counted in controller clock cycles, and each is derived from a clock-period parameter and a nanosecond figure.

Commands are offered on a simple valid/ready command port. Each command carries a one-cold chip select, the row/column/write strobes, a bank field that selects the mode register, and an address payload. The operating values for the four mode registers come in on input ports. The block forces the few bits it owns itself: precharge-all, DLL enable, DLL reset and the calibration field.

When the last device is finished, a sticky completion flag rises. One cycle later the enable for the periodic refresh engine rises.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset, both clock-enables stay low and no command is offered for at least PWR_CYC cycles, where PWR_CYC = ceil(PWRUP_NS*1000/CLK_PS).
- R2: No command is offered before `phy_locked` has been seen high.
- R3: The first command for each device is a NOP with {ras_n,cas_n,we_n}=111, bank 0 and address 0. The clock-enable of that device is high in the cycle after the NOP is accepted and stays high. Every later command for that device finds it high.
- R4: At least NOP_CYC = ceil(NOP_WAIT_NS*1000/CLK_PS) cycles after the NOP, the following commands are offered in order. (a) Precharge-all: code 010, bank 0, only address bit 10 set. (b) Mode register 2: code 000, bank 2, `emrs2_val`. (c) Mode register 3: code 000, bank 3, `emrs3_val`. (d) Extended mode register: code 000, bank 1, `emrs_val` with bit 0 and bits 9:7 cleared. (e) Mode register: code 000, bank 0, `mrs_val` with bit 8 set (DLL reset).
- R5: Next come a precharge-all, two refreshes (code 001, bank 0, address 0), and a mode-register write with `mrs_val` and bit 8 cleared.
- R6: At least MRS_WAIT_CYC cycles after that mode-register write, the block issues two extended-mode writes, both built from the R4(d) value. The first has bits 9:7 = 111 (calibration default). The second has bits 9:7 = 000 (calibration exit).
- R7: With `two_dev` high, the whole R3–R6 run repeats for device 1, selected by `cmd_cs_n`=01 (device 0 uses 10). With `two_dev` low, `cke[1]` stays low.
- R8: `aref_en` stays low until `init_done` is high, and rises exactly one cycle after it.
- R9: `init_done` rises in the cycle after the final command is accepted, and stays high until reset.
- R10: While `cmd_valid` is high and `cmd_ready` is low, the offered command is held unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_locked | input | 1 | PHY delay line lock indication |
| two_dev | input | 1 | High when a second device is fitted |
| emrs2_val | input | ADDR_W | Payload for mode register 2 |
| emrs3_val | input | ADDR_W | Payload for mode register 3 |
| emrs_val | input | ADDR_W | Payload for the extended mode register |
| mrs_val | input | ADDR_W | Payload for the mode register |
| cmd_ready | input | 1 | Command port accepts the offered command |
| cmd_valid | output | 1 | A command is offered |
| cmd_cs_n | output | 2 | One-cold chip select, 11 when idle |
| cmd_ras_n | output | 1 | Row strobe |
| cmd_cas_n | output | 1 | Column strobe |
| cmd_we_n | output | 1 | Write strobe |
| cmd_bank | output | BANK_W | Bank / mode register select |
| cmd_addr | output | ADDR_W | Address payload |
| cke | output | 2 | Per-device clock enable |
| init_done | output | 1 | Initialization complete (sticky) |
| aref_en | output | 1 | Enable for the periodic refresh engine |

## Verification
Two events can land on the same cycle. The power-up counter can expire in the very cycle the PHY lock rises, and a command hand-off can be stalled by `cmd_ready` at the moment a wait interval would begin. One run raises `phy_locked` exactly at the PWR_CYC mark. The check is that the first NOP is accepted neither before the lock nor before PWR_CYC. Other runs withhold `cmd_ready` in repeating patterns, so the back-pressure falls on NOP and mode-register hand-offs. There the scoreboard judges both the command order and the minimum gap measured from the actual acceptance.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // {ras_n, cas_n, we_n} with the chip select active
  typedef enum logic [2:0] {
    CMD_MODE  = 3'b000,
    CMD_REFR  = 3'b001,
    CMD_PREA  = 3'b010,
    CMD_NOP   = 3'b111
  } cmd_e;

  typedef enum logic [3:0] {
    STP_NOP, STP_PREA_A, STP_MR2, STP_MR3, STP_EMR_DLL, STP_MR_RST,
    STP_PREA_B, STP_REFR_A, STP_REFR_B, STP_MR_RUN, STP_OCD_DEF, STP_OCD_EXIT
  } step_e;

  typedef enum logic [1:0] {GAP_NONE, GAP_SHORT, GAP_LONG} gap_e;

  typedef enum logic [1:0] {FSM_PWRUP, FSM_ISSUE, FSM_GAP, FSM_DONE} fsm_e;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
  parameter int CNT_W    = 14,
  parameter int INIT_VAL = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(INIT_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0) && !load;

  // The count never jumps upward unless reloaded
  p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
endmodule

// File: rtl/init_step_decode.sv
module init_step_decode
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  step_e             step,
  input  logic [ADDR_W-1:0] emrs2_val,
  input  logic [ADDR_W-1:0] emrs3_val,
  input  logic [ADDR_W-1:0] emrs_val,
  input  logic [ADDR_W-1:0] mrs_val,
  output cmd_e              cmd,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] addr,
  output gap_e              gap_after,
  output logic              last_step
);
  localparam logic [ADDR_W-1:0] ALL_BANKS = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] DLL_RESET = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] OCD_FIELD = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] DLL_OFF   = ADDR_W'(1);

  logic [ADDR_W-1:0] ext_base;
  assign ext_base = emrs_val & ~(OCD_FIELD | DLL_OFF);

  always_comb begin
    cmd       = CMD_MODE;
    bank      = '0;
    addr      = '0;
    gap_after = GAP_NONE;
    last_step = 1'b0;
    unique case (step)
      STP_NOP:      begin cmd = CMD_NOP; gap_after = GAP_SHORT; end
      STP_PREA_A,
      STP_PREA_B:   begin cmd = CMD_PREA; addr = ALL_BANKS; end
      STP_MR2:      begin bank = BANK_W'(2); addr = emrs2_val; end
      STP_MR3:      begin bank = BANK_W'(3); addr = emrs3_val; end
      STP_EMR_DLL:  begin bank = BANK_W'(1); addr = ext_base; end
      STP_MR_RST:   addr = mrs_val | DLL_RESET;
      STP_REFR_A,
      STP_REFR_B:   cmd = CMD_REFR;
      STP_MR_RUN:   begin addr = mrs_val & ~DLL_RESET; gap_after = GAP_LONG; end
      STP_OCD_DEF:  begin bank = BANK_W'(1); addr = ext_base | OCD_FIELD; end
      STP_OCD_EXIT: begin bank = BANK_W'(1); addr = ext_base; last_step = 1'b1; end
      default:      cmd = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PS       = 20000,
  parameter int PWRUP_NS     = 200000,
  parameter int NOP_WAIT_NS  = 400,
  parameter int MRS_WAIT_CYC = 200,
  parameter int ADDR_W       = 14,
  parameter int BANK_W       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_locked,
  input  logic              two_dev,
  input  logic [ADDR_W-1:0] emrs2_val,
  input  logic [ADDR_W-1:0] emrs3_val,
  input  logic [ADDR_W-1:0] emrs_val,
  input  logic [ADDR_W-1:0] mrs_val,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output logic [1:0]        cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [1:0]        cke,
  output logic              init_done,
  output logic              aref_en
);
  localparam int PWR_CYC  = (PWRUP_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int NOP_CYC  = (NOP_WAIT_NS * 1000 + CLK_PS - 1) / CLK_PS;
  localparam int WAIT_MAX = (PWR_CYC > MRS_WAIT_CYC) ?
                            ((PWR_CYC > NOP_CYC) ? PWR_CYC : NOP_CYC) :
                            ((MRS_WAIT_CYC > NOP_CYC) ? MRS_WAIT_CYC : NOP_CYC);
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  fsm_e              state_q, state_d;
  step_e             step_q, step_d;
  logic              dev_q, dev_d;
  logic [1:0]        cke_q, cke_d;
  logic              done_q, done_d;
  logic              aref_q;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  cmd_e              dec_cmd;
  gap_e              dec_gap;
  logic              dec_last;
  logic              accept;

  init_step_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_decode (
    .step      (step_q),
    .emrs2_val (emrs2_val),
    .emrs3_val (emrs3_val),
    .emrs_val  (emrs_val),
    .mrs_val   (mrs_val),
    .cmd       (dec_cmd),
    .bank      (cmd_bank),
    .addr      (cmd_addr),
    .gap_after (dec_gap),
    .last_step (dec_last)
  );

  init_wait_timer #(.CNT_W(CNT_W), .INIT_VAL(PWR_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_s),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign cmd_valid = (state_q == FSM_ISSUE);
  assign accept    = cmd_valid && cmd_ready;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    dev_d    = dev_q;
    cke_d    = cke_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      FSM_PWRUP: if (tmr_expired && phy_locked) state_d = FSM_ISSUE;
      FSM_ISSUE: if (cmd_ready) begin
        if (step_q == STP_NOP) cke_d[dev_q] = 1'b1;
        if (dec_last) begin
          step_d = STP_NOP;
          if (two_dev && !dev_q) dev_d = 1'b1;
          else begin
            state_d = FSM_DONE;
            done_d  = 1'b1;
          end
        end else begin
          step_d = step_e'(4'(step_q + 4'd1));
        end
        if (dec_gap == GAP_SHORT) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(NOP_CYC);
          state_d  = FSM_GAP;
        end else if (dec_gap == GAP_LONG) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(MRS_WAIT_CYC);
          state_d  = FSM_GAP;
        end
      end
      FSM_GAP:   if (tmr_expired) state_d = FSM_ISSUE;
      default:   state_d = FSM_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= FSM_PWRUP;
      step_q  <= STP_NOP;
      dev_q   <= 1'b0;
      cke_q   <= 2'b00;
      done_q  <= 1'b0;
      aref_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      dev_q   <= dev_d;
      cke_q   <= cke_d;
      done_q  <= done_d;
      aref_q  <= done_q;
    end
  end

  assign cmd_cs_n  = cmd_valid ? ~(2'b01 << dev_q) : 2'b11;
  assign {cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_valid ? dec_cmd : CMD_NOP;
  assign cke       = cke_q;
  assign init_done = done_q;
  assign aref_en   = aref_q;

  p_silent_pwrup_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == FSM_PWRUP) |-> (!cmd_valid && cke == 2'b00));
  p_lock_gate_r2: assert property (@(posedge clk) disable iff (!rst_s)
    ($rose(cmd_valid) && cke == 2'b00) |-> $past(phy_locked));
  p_cke_before_cmd_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && dec_cmd != CMD_NOP) |-> cke[dev_q]);
  p_aref_after_done_r8: assert property (@(posedge clk) disable iff (!rst_s)
    aref_en |-> init_done);
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_s)
    init_done |=> init_done);
  p_hold_offer_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
      $stable(cmd_bank) && $stable(cmd_cs_n)));
endmodule

// File: tb/ddr2_init_seq_bench.sv
`timescale 1ns/1ps
module ddr2_init_seq_bench;
  localparam int AW     = 14;
  localparam int BW     = 3;
  localparam int PWR    = 10000;   // 200 us at 20 ns
  localparam int NOPW   = 20;      // 400 ns at 20 ns
  localparam int MRSW   = 200;
  localparam logic [AW-1:0] B10 = 14'h0400;
  localparam logic [AW-1:0] B8  = 14'h0100;
  localparam logic [AW-1:0] OCD = 14'h0380;

  typedef struct packed {
    logic [1:0]    cs_n;
    logic [2:0]    cmd;
    logic [BW-1:0] bank;
    logic [AW-1:0] addr;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, phy_locked, two_dev, cmd_ready;
  logic [AW-1:0] emrs2_val, emrs3_val, emrs_val, mrs_val;
  logic cmd_valid, cmd_ras_n, cmd_cas_n, cmd_we_n, init_done, aref_en;
  logic [1:0] cmd_cs_n, cke;
  logic [BW-1:0] cmd_bank;
  logic [AW-1:0] cmd_addr;

  int checks = 0, fails = 0;
  int mon_cyc = 0, gcnt = 0, ready_mode = 0;
  int lock_cyc = 0, t_nop = 0, t_run = 0, pos = 0, devn = 0;
  bit mon_en = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  ddr2_init_seq u_ddr2_init_seq (
    .clk(clk), .rst_n(rst_n), .phy_locked(phy_locked), .two_dev(two_dev),
    .emrs2_val(emrs2_val), .emrs3_val(emrs3_val), .emrs_val(emrs_val),
    .mrs_val(mrs_val), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
    .cmd_we_n(cmd_we_n), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cke(cke), .init_done(init_done), .aref_en(aref_en));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int p);
    if (p == 0) return "R3";
    if (p <= 5) return "R4";
    if (p <= 9) return "R5";
    return "R6";
  endfunction

  task automatic push(input logic [1:0] cs, input logic [2:0] c,
                      input logic [BW-1:0] b, input logic [AW-1:0] a);
    item_t it;
    it = '{cs_n: cs, cmd: c, bank: b, addr: a};
    exp_q.push_back(it);
  endtask

  // driver side: expected run for one device
  task automatic push_device(input int d);
    logic [1:0]    cs;
    logic [AW-1:0] base;
    cs   = (d == 0) ? 2'b10 : 2'b01;
    base = emrs_val & ~(OCD | 14'h0001);
    push(cs, 3'b111, 3'd0, '0);
    push(cs, 3'b010, 3'd0, B10);
    push(cs, 3'b000, 3'd2, emrs2_val);
    push(cs, 3'b000, 3'd3, emrs3_val);
    push(cs, 3'b000, 3'd1, base);
    push(cs, 3'b000, 3'd0, mrs_val | B8);
    push(cs, 3'b010, 3'd0, B10);
    push(cs, 3'b001, 3'd0, '0);
    push(cs, 3'b001, 3'd0, '0);
    push(cs, 3'b000, 3'd0, mrs_val & ~B8);
    push(cs, 3'b000, 3'd1, base | OCD);
    push(cs, 3'b000, 3'd1, base);
  endtask

  always @(posedge clk) begin
    gcnt++;
    #2;
    case (ready_mode)
      0: cmd_ready = 1'b1;
      1: cmd_ready = (gcnt % 3) != 0;
      default: cmd_ready = (gcnt % 7) >= 3;
    endcase
  end

  // monitor: pops and compares at each accepted command
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      mon_cyc++;
      if (cmd_valid && cmd_ready) begin
        item_t got, e;
        string rq;
        got = '{cs_n: cmd_cs_n, cmd: {cmd_ras_n, cmd_cas_n, cmd_we_n},
                bank: cmd_bank, addr: cmd_addr};
        rq = req_of(pos);
        if (exp_q.size() == 0) check(1'b0, "R7", int'(got), 0);
        else begin
          e = exp_q.pop_front();
          check(got == e, (got.cs_n != e.cs_n) ? "R7" : rq, int'(got), int'(e));
        end
        check(!init_done && !aref_en, "R8", {init_done, aref_en}, 0);
        if (pos == 0) begin
          check(cke[devn] == 1'b0, "R3", cke, 0);
          if (devn == 0) begin
            check(mon_cyc >= PWR, "R1", mon_cyc, PWR);
            check(mon_cyc > lock_cyc && phy_locked, "R2", mon_cyc, lock_cyc + 1);
          end
          t_nop = mon_cyc;
        end else begin
          check(cke[devn] == 1'b1, "R3", cke, 2'b11);
        end
        if (pos == 1) check(mon_cyc - t_nop >= NOPW, "R4", mon_cyc - t_nop, NOPW);
        if (pos == 9) t_run = mon_cyc;
        if (pos == 10) check(mon_cyc - t_run >= MRSW, "R6", mon_cyc - t_run, MRSW);
        pos++;
        if (pos == 12) begin pos = 0; devn++; end
      end
    end
  end

  task automatic run(input bit two, input int lock_at, input int rmode,
                     input logic [AW-1:0] e2, input logic [AW-1:0] e3,
                     input logic [AW-1:0] e1, input logic [AW-1:0] m0);
    mon_en = 0;
    rst_n = 1'b0;
    phy_locked = 1'b0;
    two_dev = two; ready_mode = rmode;
    emrs2_val = e2; emrs3_val = e3; emrs_val = e1; mrs_val = m0;
    exp_q.delete();
    pos = 0; devn = 0; mon_cyc = 0; lock_cyc = 0;
    repeat (3) @(negedge clk);
    check(!cmd_valid && cke == 2'b00 && !init_done && !aref_en, "R1",
          {cmd_valid, cke, init_done, aref_en}, 0);
    push_device(0);
    if (two) push_device(1);
    @(posedge clk); #3;
    rst_n = 1'b1; mon_en = 1;
    while (mon_cyc < lock_at) @(posedge clk);
    #2; lock_cyc = mon_cyc; phy_locked = 1'b1;
    while (!init_done) @(negedge clk);
    // first negedge with init_done high: aref still low
    check(aref_en == 1'b0, "R8", aref_en, 0);
    check(exp_q.size() == 0, "R9", exp_q.size(), 0);
    @(negedge clk);
    check(aref_en == 1'b1, "R8", aref_en, 1);
    check(cke == (two ? 2'b11 : 2'b01), "R7", cke, two ? 3 : 1);
    repeat (40) @(negedge clk);
    check(init_done && aref_en && !cmd_valid, "R9",
          {init_done, aref_en, cmd_valid}, 3'b110);
  endtask

  initial begin
    rst_n = 1'b0; cmd_ready = 1'b1;
    // single device, early lock, no back-pressure
    run(1'b0, 0, 0, 14'h0000, 14'h0000, 14'h0044, 14'h0642);
    // two devices, late lock, stalls, payload bits that must be forced
    run(1'b1, 12000, 1, 14'h0080, 14'h0000, 14'h0fc5, 14'h0753);
    // two devices, lock exactly at the power-up mark, burst stalls (R10)
    run(1'b1, PWR, 2, 14'h0008, 14'h0001, 14'h0381, 14'h0a32);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule